// File: doc/BRIEF.md
# Latching Priority Interrupt Arbiter

This block collects a set of maskable hardware interrupt requests and one software interrupt request that no mask can block. When the processor begins interrupt processing it pulses a start strobe. On that strobe the block picks one winner among the eligible requests and freezes the result as a constant vector code. The processor uses that code to pick the vector address it fetches. Stacking and the vector fetch themselves happen outside this block.

The frozen code cannot be changed by any request that arrives later, whatever its priority. It is released in only two ways. The first is a serviced strobe, which also retires the winning source. The second is the mask bit going from set to clear, which frees the choice but leaves the source pending.

Each request line is level-sensitive. The block holds it in a sticky bit until the serviced strobe retires that same source. A pending flag tells the processor that an eligible request is waiting and that nothing is frozen yet.

Top module: `lat_arb`

## Requirements
- R1: Source numbering and codes: the software interrupt is source 0 and hardware line `hw_req[i]` is source i+1. The vector code of source k is k+1, and code 0 means nothing is latched. When several eligible requests exist together, the lowest-numbered source wins.
- R2: A `arb_start` pulse in a cycle with no latched result and at least one eligible request latches the winner. Its code appears on `vec_code` after that clock edge. If nothing is eligible, the pulse leaves `vec_code` at 0.
- R3: While a result is latched, `vec_code` holds its value. Neither a new request of any priority nor a further `arb_start` pulse changes it.
- R4: While `imask` is 1, hardware requests are not eligible: they neither raise `pend_out` nor win arbitration. They do remain pending.
- R5: The software request is eligible whatever the value of `imask`.
- R6: A request stays pending after its line drops. Only a `svc_done` pulse while that source is latched retires it. A `svc_done` pulse with nothing latched has no effect.
- R7: A `svc_done` pulse while latched returns `vec_code` to 0 after the edge.
- R8: `imask` going from 1 to 0 while a result is latched returns `vec_code` to 0 after the edge. The source is not retired.
- R9: `pend_out` is 1 exactly when no result is latched and an eligible request exists, counting both the live request lines and the sticky pending bits.
- R10: A synchronous active-high `rst` clears the latch and every sticky pending bit.
- R11: If `svc_done` retires a source in the same cycle that its line is still high, the retire takes effect. The source is pending again only if its line is still high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_req | input | NUM_HW | Maskable hardware request lines, level-sensitive |
| swi_req | input | 1 | Software interrupt request, not maskable |
| imask | input | 1 | Interrupt mask bit; 1 blocks hardware requests |
| arb_start | input | 1 | Start-of-interrupt-processing strobe |
| svc_done | input | 1 | Serviced strobe for the latched source |
| pend_out | output | 1 | An eligible request waits and nothing is latched |
| vec_code | output | CODE_W | Latched vector code, 0 when idle |

## Verification
Two functions can meet in one cycle. The first is a serviced strobe arriving in the same cycle that the retired source's line is still high. The second is a start strobe arriving in the same cycle as a serviced strobe, or in the same cycle that a higher-priority request first appears after latching. The stimulus table places these on single cycles. It then checks two things: the pending flag just before the edge, and the vector code just after it. This shows that the retire wins over the live level, that the frozen choice ignores both the new request and the extra start pulse, and that the source reappears only when its line stays high.

// File: rtl/lat_arb_pkg.sv
package lat_arb_pkg;
  // width of a code that holds 0 (idle) plus one value per source
  function automatic int code_width(input int n_src);
    return $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/lat_arb_pend.sv
module lat_arb_pend #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] retire,
  output logic [NUM_SRC-1:0] eff
);
  logic [NUM_SRC-1:0] sticky_q;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) sticky_q[g] <= 1'b0;
        else     sticky_q[g] <= (sticky_q[g] | req[g]) & ~retire[g];
      end
      assign eff[g] = sticky_q[g] | req[g];
    end
  endgenerate
endmodule

// File: rtl/lat_arb_pick.sv
module lat_arb_pick #(
  parameter int NUM_SRC = 5,
  parameter int CODE_W  = 3
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               any,
  output logic [CODE_W-1:0]  code
);
  // lowest index wins; code = index + 1
  function automatic logic [CODE_W-1:0] first_code(input logic [NUM_SRC-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) c = CODE_W'(i + 1);
    return c;
  endfunction

  assign any  = |cand;
  assign code = first_code(cand);
endmodule

// File: rtl/lat_arb_hold.sv
module lat_arb_hold #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CODE_W-1:0] take_code,
  input  logic              release_svc,
  input  logic              release_mask,
  output logic              held,
  output logic [CODE_W-1:0] held_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      held_code <= '0;
    end else if (held && (release_svc || release_mask)) begin
      held      <= 1'b0;
      held_code <= '0;
    end else if (!held && take) begin
      held      <= 1'b1;
      held_code <= take_code;
    end
  end
endmodule

// File: rtl/lat_arb.sv
module lat_arb #(
  parameter int NUM_HW  = 4,
  parameter int NUM_SRC = NUM_HW + 1,
  parameter int CODE_W  = lat_arb_pkg::code_width(NUM_HW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_HW-1:0] hw_req,
  input  logic              swi_req,
  input  logic              imask,
  input  logic              arb_start,
  input  logic              svc_done,
  output logic              pend_out,
  output logic [CODE_W-1:0] vec_code
);
  logic [NUM_SRC-1:0] req_all;
  logic [NUM_SRC-1:0] eff;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] retire;
  logic               any_elig;
  logic [CODE_W-1:0]  win_code;
  logic               held;
  logic [CODE_W-1:0]  held_code;
  logic               imask_q;
  logic               mask_fall;
  logic               svc_hit;
  logic               take;

  assign req_all = {hw_req, swi_req};

  // only the latched source is retired by the serviced strobe
  assign svc_hit = held && svc_done;
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ret
      assign retire[g] = svc_hit && (held_code == CODE_W'(g + 1));
    end
  endgenerate

  lat_arb_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .req(req_all), .retire(retire), .eff(eff)
  );

  // source 0 (software) ignores the mask
  assign eligible = {eff[NUM_SRC-1:1] & {NUM_HW{~imask}}, eff[0]};

  lat_arb_pick #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_pick (
    .cand(eligible), .any(any_elig), .code(win_code)
  );

  always_ff @(posedge clk) begin
    if (rst) imask_q <= 1'b0;
    else     imask_q <= imask;
  end
  assign mask_fall = imask_q && !imask;
  assign take      = arb_start && any_elig;

  lat_arb_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst(rst), .take(take), .take_code(win_code),
    .release_svc(svc_done), .release_mask(mask_fall),
    .held(held), .held_code(held_code)
  );

  assign pend_out = !held && any_elig;
  assign vec_code = held_code;
endmodule

// File: rtl/lat_arb_chk.sv
module lat_arb_chk #(
  parameter int NUM_HW = 4,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_HW-1:0] hw_req,
  input logic              swi_req,
  input logic              imask,
  input logic              arb_start,
  input logic              svc_done,
  input logic              pend_out,
  input logic [CODE_W-1:0] vec_code,
  input logic              held,
  input logic              mask_fall
);
  // R3: frozen code only changes through a release
  a_r3_frozen_code: assert property (@(posedge clk) disable iff (rst)
    (held && !svc_done && !mask_fall) |=> $stable(vec_code));

  // R7: serviced strobe returns the code to idle
  a_r7_svc_release: assert property (@(posedge clk) disable iff (rst)
    (held && svc_done) |=> (vec_code == '0));

  // R8: mask clearing returns the code to idle
  a_r8_mask_release: assert property (@(posedge clk) disable iff (rst)
    (held && mask_fall) |=> (vec_code == '0));

  // R2: start with an eligible request latches a nonzero code
  a_r2_latch_on_start: assert property (@(posedge clk) disable iff (rst)
    (pend_out && arb_start) |=> (vec_code != '0));

  // R9: pending never shows while a code is latched
  a_r9_pend_idle_only: assert property (@(posedge clk) disable iff (rst)
    (vec_code != '0) |-> !pend_out);

  // R5: software request always makes something visible
  a_r5_swi_visible: assert property (@(posedge clk) disable iff (rst)
    swi_req |-> (pend_out || vec_code != '0));

  // R10: synchronous reset clears the latch
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (vec_code == '0));
endmodule

bind lat_arb lat_arb_chk #(.NUM_HW(NUM_HW), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .hw_req(hw_req), .swi_req(swi_req), .imask(imask),
  .arb_start(arb_start), .svc_done(svc_done), .pend_out(pend_out),
  .vec_code(vec_code), .held(held), .mask_fall(mask_fall)
);

// File: tb/lat_arb_tb.sv
`timescale 1ns/100ps
module lat_arb_tb;
  localparam int NHW = 4;
  localparam int CW  = 3;
  localparam int NV  = 27;

  logic           clk = 1'b0;
  logic           rst;
  logic [NHW-1:0] hw_req;
  logic           swi_req, imask, arb_start, svc_done;
  logic           pend_out;
  logic [CW-1:0]  vec_code;
  int             n_chk = 0;
  int             n_bad = 0;
  bit             done  = 1'b0;

  always #2.5 clk = ~clk;

  lat_arb #(.NUM_HW(NHW)) u_dut (
    .clk(clk), .rst(rst), .hw_req(hw_req), .swi_req(swi_req), .imask(imask),
    .arb_start(arb_start), .svc_done(svc_done),
    .pend_out(pend_out), .vec_code(vec_code)
  );

  // {hw[3:0], swi, imask, start, svc, exp_pend (before edge), exp_code (after edge)}
  // codes: swi=1, hw0=2, hw1=3, hw2=4, hw3=5, idle=0
  localparam logic [11:0] VEC [NV] = '{
    {4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0}, // 0  idle R9
    {4'b0100,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0}, // 1  hw2 pulse R9
    {4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd4}, // 2  sticky hw2 latched R6 R2
    {4'b0001,1'b0,1'b0,1'b1,1'b0,1'b0,3'd4}, // 3  hw0 cannot displace R3
    {4'b0000,1'b0,1'b0,1'b0,1'b1,1'b0,3'd0}, // 4  serviced R7
    {4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0}, // 5  hw0 still pending R6
    {4'b0000,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0}, // 6  masked R4
    {4'b0000,1'b1,1'b1,1'b1,1'b0,1'b1,3'd1}, // 7  swi under mask R5
    {4'b0000,1'b0,1'b1,1'b0,1'b1,1'b0,3'd0}, // 8  serviced swi R7
    {4'b1000,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0}, // 9  hw3 masked R4
    {4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0}, // 10 unmask, pending R9
    {4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd2}, // 11 lowest wins R1
    {4'b0000,1'b1,1'b0,1'b0,1'b0,1'b0,3'd2}, // 12 swi cannot displace R3
    {4'b0000,1'b0,1'b1,1'b0,1'b0,1'b0,3'd2}, // 13 mask set, held R3
    {4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0}, // 14 mask cleared R8
    {4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd1}, // 15 swi first R1
    {4'b0000,1'b0,1'b0,1'b1,1'b1,1'b0,3'd0}, // 16 svc wins over start R7
    {4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd2}, // 17 hw0 kept by R8
    {4'b0001,1'b0,1'b0,1'b0,1'b1,1'b0,3'd0}, // 18 svc with line high R11
    {4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0}, // 19 only hw3 left R11
    {4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd5}, // 20 hw3 code R1
    {4'b0000,1'b0,1'b0,1'b0,1'b1,1'b0,3'd0}, // 21 R7
    {4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0}, // 22 all retired R11
    {4'b0010,1'b0,1'b0,1'b0,1'b1,1'b1,3'd0}, // 23 idle svc ignored R6
    {4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd3}, // 24 hw1 kept R6
    {4'b0000,1'b0,1'b0,1'b0,1'b1,1'b0,3'd0}, // 25 R7
    {4'b0000,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0}  // 26 start, nothing eligible R2
  };

  function automatic string tag_of(input int k);
    case (k)
      1, 10:             return "R9";
      2, 26:             return "R2";
      3, 12, 13:         return "R3";
      4, 8, 16, 21, 25:  return "R7";
      5, 23, 24:         return "R6";
      6, 9:              return "R4";
      7:                 return "R5";
      11, 15, 20:        return "R1";
      14, 17:            return "R8";
      18, 19, 22:        return "R11";
      default:           return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [NHW-1:0] h, input logic s, input logic m,
                       input logic st, input logic sv);
    hw_req = h; swi_req = s; imask = m; arb_start = st; svc_done = sv;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    check("R10 reset code", int'(vec_code), 0);
    check("R10 reset pend", int'(pend_out), 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][11:8], VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4]);
      #1;
      check({tag_of(k), " pend step ", $sformatf("%0d", k)}, int'(pend_out), int'(VEC[k][3]));
      @(posedge clk);
      #1;
      check({tag_of(k), " code step ", $sformatf("%0d", k)}, int'(vec_code), int'(VEC[k][2:0]));
    end

    // R10: reset while latched, with a sticky request stored
    drive(4'b0100, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    drive('0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R10 pre-reset latch", int'(vec_code), 4);
    drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(4'b0001, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    rst = 1'b1;
    drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    rst = 1'b0;
    check("R10 reset drops latch", int'(vec_code), 0);
    check("R10 reset clears sticky", int'(pend_out), 0);
    drive('0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R10 nothing left to latch", int'(vec_code), 0);

    // R4: masked hardware stays pending and wins once unmasked
    drive(4'b0010, 1'b0, 1'b1, 1'b0, 1'b0);
    #1;
    check("R4 masked pend", int'(pend_out), 0);
    @(posedge clk); #1;
    drive('0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R4 kept while masked", int'(vec_code), 3);

    drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    finish_run();
  end
endmodule